// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Bank

This block is a memory-mapped bank of general-purpose I/O pins, 32 by default. Software reaches it through a plain 64-bit register port. It reads the pins through one shared input register. It moves the output latch only through a write-one-to-set register and a write-one-to-clear register, so no read-modify-write is needed. Every pin also has a configuration word of its own that holds the following:

- output enable
- input inversion
- interrupt enable
- interrupt trigger mode
- an alternate-function select

Each pad input passes through a two-flop synchroniser. The pin's inversion bit is then applied, and the result feeds both the input register and the interrupt logic. The low pins of the bank can raise interrupts, pins 0 to 15 by default. Each can be set to trigger on a rising edge, a falling edge, a high level or a low level. An edge interrupt is held pending until software clears it. A level interrupt follows the pin.

The alternate-function select is stored and reported only. A pin with a nonzero select has its pad driver released so that another block can own it. Routing that function to other logic is not part of this block.

Top module: `gpio_bank`

## Requirements
- R1: After reset these are all zero: the output latch, every configuration word, every pad output enable, every interrupt output, every pending bit, and bus_rvalid.
- R2: A write to word address 0x08 sets the output latch bit of every pin whose data bit is 1 and leaves the pins whose bit is 0 unchanged. The latch drives pad_out directly.
- R3: A write to 0x10 clears the latch bit of every pin whose data bit is 1 and leaves the others unchanged. A read of 0x08 or 0x10 returns the latch.
- R4: A read of 0x00 returns, for pin n in bit n, the pad input after two synchroniser flops, XORed with the pin's inversion bit. Bits above the pin count read 0.
- R5: Pin n's configuration word is at 0x100 + 8*n and reads back its written fields at these positions:
  - bit 0: output enable
  - bit 1: inversion
  - bit 2: interrupt enable
  - bits 5:4: trigger mode
  - bits 26:16: function select

  All other writable bits read 0. Bits 63:62 are a read-only role field: 2 when the select is nonzero, else 1 when output enable is set, else 0.
- R6: pad_oe[n] is 1 exactly when pin n has output enable set and a zero function select. Releasing the pad does not change the latch.
- R7: Trigger mode 0 (rising) and mode 1 (falling) latch a pending bit on that edge of the inverted, synchronised input. The pending bit holds until software writes 1 to that pin's bit at 0x18. A read of 0x18 returns the pending bits.
- R8: Trigger mode 2 drives irq[n] while the inverted input is 1, and mode 3 drives it while the inverted input is 0. Neither mode latches a pending bit.
- R9: Only pins below NUM_IRQ have interrupt enable and trigger mode. On other pins those fields read 0.
- R10: With interrupt enable clear, irq[n] is 0 and edges set no pending bit.
- R11: bus_rvalid is 1 in the cycle after each bus_rd_en and 0 otherwise. Unmapped addresses read 0. Writes to 0x00 and to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits 2:0 are ignored |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd_en |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output latch to the pads |
| pad_oe | output | NUM_PINS | Pad driver enables |
| irq | output | NUM_IRQ | Per-pin interrupt outputs |

## Verification
The assertions take for granted that bus_wr_en and bus_rd_en are never both high in a cycle. They also assume the strobes are low during reset. Under those assumptions the latch and the pad enables move only in a cycle that follows a write. The stimulus drives the strobes one at a time from tasks that raise a strobe for exactly one cycle. Each pad input is held for at least three cycles, so every change crosses the synchroniser before it is checked.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W    = 64;
  localparam int OE_BIT   = 0;
  localparam int INV_BIT  = 1;
  localparam int IE_BIT   = 2;
  localparam int MODE_LSB = 4;
  localparam int SEL_LSB  = 16;
  localparam int SEL_W    = 11;
  localparam int ROLE_LSB = 62;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    ROLE_IN  = 2'd0,
    ROLE_OUT = 2'd1,
    ROLE_ALT = 2'd2
  } role_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    trig_e            mode;
    logic             ie;
    logic             inv;
    logic             oe;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
    pin_cfg_t c;
    c.oe   = w[OE_BIT];
    c.inv  = w[INV_BIT];
    c.ie   = w[IE_BIT];
    c.mode = trig_e'(w[MODE_LSB +: 2]);
    c.sel  = w[SEL_LSB +: SEL_W];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] word_from_cfg(input pin_cfg_t c);
    logic [BUS_W-1:0] w;
    role_e            r;
    w                   = '0;
    w[OE_BIT]           = c.oe;
    w[INV_BIT]          = c.inv;
    w[IE_BIT]           = c.ie;
    w[MODE_LSB +: 2]    = c.mode;
    w[SEL_LSB +: SEL_W] = c.sel;
    if (c.sel != '0)  r = ROLE_ALT;
    else if (c.oe)    r = ROLE_OUT;
    else              r = ROLE_IN;
    w[ROLE_LSB +: 2]    = r;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int NUM_IRQ  = 16,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_pin,
  input  logic [BUS_W-1:0] wr_data,
  output pin_cfg_t         cfg_q [NUM_PINS]
);
  pin_cfg_t wr_cfg;
  assign wr_cfg = cfg_from_word(wr_data);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_cfg_t next_cfg;
    always_comb begin
      next_cfg = wr_cfg;
      if (g >= NUM_IRQ) begin
        next_cfg.ie   = 1'b0;
        next_cfg.mode = TRIG_RISE;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[g] <= '0;
      else if (wr_en && wr_pin == PIN_W'(g))
        cfg_q[g] <= next_cfg;
    end
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  level_in,
  input  logic  enable,
  input  trig_e mode,
  input  logic  clear,
  output logic  pending,
  output logic  irq_out
);
  logic prev_level;
  logic edge_hit;
  logic level_hit;

  always_comb begin
    unique case (mode)
      TRIG_RISE: edge_hit = level_in & ~prev_level;
      TRIG_FALL: edge_hit = ~level_in & prev_level;
      default:   edge_hit = 1'b0;
    endcase
    level_hit = (mode == TRIG_HIGH) ? level_in : ~level_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_level <= 1'b0;
      pending    <= 1'b0;
    end else begin
      prev_level <= level_in;
      if (enable && edge_hit) pending <= 1'b1;
      else if (clear)         pending <= 1'b0;
    end
  end

  assign irq_out = enable & (mode[1] ? level_hit : pending);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_PINS = 32,
  parameter int          NUM_IRQ  = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] CFG_BASE = 12'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_IRQ-1:0]  irq
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [IDX_W-1:0] IDX_IN   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_SET  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CLR  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_PEND = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_CFG  = IDX_W'(CFG_BASE >> 3);

  logic [IDX_W-1:0]    word_idx;
  logic [IDX_W-1:0]    cfg_off;
  logic                cfg_hit;
  logic [PIN_W-1:0]    cfg_pin;
  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] inv_vec;
  logic [NUM_PINS-1:0] in_val;
  logic [NUM_PINS-1:0] out_latch;
  logic [NUM_IRQ-1:0]  pend_vec;
  logic [NUM_IRQ-1:0]  pend_clr;
  logic [63:0]         rd_mux;
  pin_cfg_t            cfg_q [NUM_PINS];
  logic [2:0]          unused_addr_lsb;

  assign unused_addr_lsb = bus_addr[2:0];
  assign word_idx = bus_addr[ADDR_W-1:3];
  assign cfg_off  = word_idx - IDX_CFG;
  assign cfg_hit  = (word_idx >= IDX_CFG) && (cfg_off < IDX_W'(NUM_PINS));
  assign cfg_pin  = cfg_off[PIN_W-1:0];

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (sync_q)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en && cfg_hit),
    .wr_pin  (cfg_pin),
    .wr_data (bus_wdata),
    .cfg_q   (cfg_q)
  );

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      inv_vec[i] = cfg_q[i].inv;
      pad_oe[i]  = cfg_q[i].oe && (cfg_q[i].sel == '0);
    end
  end
  assign in_val = sync_q ^ inv_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_latch <= '0;
    else if (bus_wr_en && word_idx == IDX_SET)
      out_latch <= out_latch | bus_wdata[NUM_PINS-1:0];
    else if (bus_wr_en && word_idx == IDX_CLR)
      out_latch <= out_latch & ~bus_wdata[NUM_PINS-1:0];
  end
  assign pad_out = out_latch;

  assign pend_clr = (bus_wr_en && word_idx == IDX_PEND) ? bus_wdata[NUM_IRQ-1:0] : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    gpio_irq_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (in_val[g]),
      .enable   (cfg_q[g].ie),
      .mode     (cfg_q[g].mode),
      .clear    (pend_clr[g]),
      .pending  (pend_vec[g]),
      .irq_out  (irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (word_idx == IDX_IN)                              rd_mux = 64'(in_val);
    else if (word_idx == IDX_SET || word_idx == IDX_CLR) rd_mux = 64'(out_latch);
    else if (word_idx == IDX_PEND)                       rd_mux = 64'(pend_vec);
    else if (cfg_hit)                                    rd_mux = word_from_cfg(cfg_q[cfg_pin]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [63:0]         bus_wdata,
  input logic                bus_rvalid,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);
  logic set_wr, clr_wr;
  assign set_wr = bus_wr_en && (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(1));
  assign clr_wr = bus_wr_en && (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(2));

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R2
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pad_out)); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == '0)); // R3
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pad_oe)); // R6
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rvalid); // R11
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rvalid); // R11
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr_en  (bus_wr_en),
  .bus_rd_en  (bus_rd_en),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NI = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic          rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NI-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [NP-1:0] exp_latch = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .NUM_IRQ(NI), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 rvalid", 64'(rvalid), 64'd1);
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_cfg(input int p, input logic [63:0] w);
    logic [63:0] e;
    e = w & 64'h0000_0000_07FF_0037;
    if (p >= NI) e = e & ~64'h34;
    if (w[26:16] != 0)  e[63:62] = 2'd2;
    else if (w[0])      e[63:62] = 2'd1;
    return e;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [NP-1:0] inv_e, oe_e, pat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_out", 64'(pad_out), 64'd0);
    chk("R1 pad_oe", 64'(pad_oe), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 rvalid", 64'(rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h018, d); chk("R1 pending", d, 64'd0);
    rd(12'h100, d); chk("R1 cfg0", d, 64'd0);
    rd(12'h1F8, d); chk("R1 cfg31", d, 64'd0);

    // R2 single-bit set sweep
    for (int i = 0; i < NP; i++) begin
      wr(12'h008, 64'd1 << i);
      exp_latch[i] = 1'b1;
      chk("R2 set bit", 64'(pad_out), 64'(exp_latch));
    end
    // R2/R3 mixed patterns
    for (int k = 0; k < 8; k++) begin
      pat = NP'(32'h9E37_79B9 * (k + 1));
      wr(12'h010, 64'(pat));
      exp_latch = exp_latch & ~pat;
      chk("R3 clear", 64'(pad_out), 64'(exp_latch));
      pat = NP'(32'h85EB_CA6B * (k + 3));
      wr(12'h008, 64'(pat));
      exp_latch = exp_latch | pat;
      chk("R2 set", 64'(pad_out), 64'(exp_latch));
      rd(12'h010, d); chk("R3 readback", d, 64'(exp_latch));
    end
    // R11 ignored write and unmapped reads
    wr(12'h000, '1);
    rd(12'h008, d); chk("R11 write to input ignored", d, 64'(exp_latch));
    wr(12'h200, '1);
    rd(12'h008, d); chk("R11 unmapped write ignored", d, 64'(exp_latch));
    rd(12'h020, d); chk("R11 unmapped read", d, 64'd0);
    rd(12'h200, d); chk("R11 unmapped read high", d, 64'd0);

    // R4 input path without inversion
    pad_in = 32'hA5C3_0F71; settle();
    rd(12'h000, d); chk("R4 input read", d, 64'h0000_0000_A5C3_0F71);

    // R5/R9 config sweep, R6 pad_oe, R4 inversion
    inv_e = '0; oe_e = '0;
    for (int p = 0; p < NP; p++) begin
      logic [63:0] w;
      w = 64'hFFFF_FFC0_0000_0008;
      w[0] = p[2]; w[1] = p[1] ^ p[0]; w[2] = p[0]; w[5:4] = 2'(p);
      w[26:16] = (p >= 16) ? 11'(p) : 11'd0;
      wr(12'h100 + AW'(8 * p), w);
      rd(12'h100 + AW'(8 * p), d);
      chk((p >= NI) ? "R9 irq fields masked" : "R5 cfg readback", d, exp_cfg(p, w));
      inv_e[p] = w[1];
      oe_e[p]  = w[0] && (w[26:16] == 0);
    end
    chk("R6 pad_oe", 64'(pad_oe), 64'(oe_e));
    chk("R6 latch kept", 64'(pad_out), 64'(exp_latch));
    rd(12'h000, d); chk("R4 inverted read", d, 64'(32'hA5C3_0F71 ^ inv_e));
    wr(12'h1F8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h1F8, d); chk("R9 pin31 all ones", d, 64'h8000_0000_07FF_0003);
    for (int p = 0; p < NP; p++) wr(12'h100 + AW'(8 * p), 64'd0);
    chk("R6 released", 64'(pad_oe), 64'd0);
    chk("R6 latch after release", 64'(pad_out), 64'(exp_latch));
    pad_in = '0; settle();
    wr(12'h018, '1);

    // R10 disabled interrupt
    wr(12'h118, 64'h0);
    pad_in[3] = 1'b1; settle();
    chk("R10 irq masked", 64'(irq), 64'd0);
    rd(12'h018, d); chk("R10 no pending", d, 64'd0);
    wr(12'h118, 64'h4);
    chk("R10 no late latch", 64'(irq), 64'd0);
    wr(12'h118, 64'h0);
    pad_in[3] = 1'b0; settle();

    // R7/R8 per-pin mode sweep
    for (int p = 0; p < NI; p++) begin
      logic [AW-1:0] a;
      logic [63:0] bit_p;
      a = 12'h100 + AW'(8 * p);
      bit_p = 64'd1 << p;
      // rising
      wr(a, 64'h04);
      pad_in[p] = 1'b1; settle();
      chk("R7 rise irq", 64'(irq), bit_p);
      pad_in[p] = 1'b0; settle();
      rd(12'h018, d); chk("R7 rise held", d, bit_p);
      wr(12'h018, bit_p);
      chk("R7 rise cleared", 64'(irq), 64'd0);
      // falling
      wr(a, 64'h14);
      pad_in[p] = 1'b1; settle();
      chk("R7 fall ignores rise", 64'(irq), 64'd0);
      pad_in[p] = 1'b0; settle();
      chk("R7 fall irq", 64'(irq), bit_p);
      wr(12'h018, bit_p);
      chk("R7 fall cleared", 64'(irq), 64'd0);
      // level high
      wr(a, 64'h24);
      chk("R8 high idle", 64'(irq), 64'd0);
      pad_in[p] = 1'b1; settle();
      chk("R8 high asserted", 64'(irq), bit_p);
      pad_in[p] = 1'b0; settle();
      chk("R8 high follows", 64'(irq), 64'd0);
      // level low
      wr(a, 64'h34);
      chk("R8 low asserted", 64'(irq), bit_p);
      pad_in[p] = 1'b1; settle();
      chk("R8 low follows", 64'(irq), 64'd0);
      rd(12'h018, d); chk("R8 no pending", d, 64'd0);
      wr(a, 64'h0);
      pad_in[p] = 1'b0; settle();
    end
    finish_run();
  end
endmodule